// File: doc/BRIEF.md
# Lockable Pin Override with Inversion

This block sits in the path between a set of board-level pins and the corresponding outputs. There are four passthrough lines: a power button and three keyboard lines. There are also two active-low control outputs: an embedded-controller reset and a flash write-protect. The block is purely control-path logic. Every output is computed combinationally from the current inputs and the configuration registers. Configuration writes take effect at the next clock edge. No streaming interface is involved, so all pins are plain control and status signals.

Each output has a base value. For a passthrough line, the base value is the input after the optional input inversion. For the reset and write-protect outputs, the base value is a fixed idle level. An external detection block may replace the base value with an action value. A software override, when enabled, replaces both of these. The override only applies if a permission bit exists for the requested value. One permission bit covers forcing a 0 and another covers forcing a 1.

The permission bits can be frozen by clearing a lock bit, which stays clear until reset. The override enable and value remain writable after the lock. Reset defaults force the reset and write-protect outputs low, and they stay low until software drops their override.

Top module: `pin_ovr_top`

## Requirements
- R1: Pin indices are as follows: 0 is the power button, 1 to 3 are the keys, 4 is the embedded-controller reset and 5 is the flash write-protect. With no action and no permitted override, a passthrough output `pin_out[i]` equals `raw_in[i] ^ inv_in[i]`, before output inversion.
- R2: `det_in` equals `raw_in` XOR the input-inversion mask. This is the value handed to the detection logic.
- R3: Output inversion is applied after the override choice, and only on bits 0 to 3. Bits 4 and 5 are never inverted.
- R4: When `act_req[j]` is 1, the base value of output j is `act_val[j]`. Otherwise the base value of bit 4 is 1 and the base value of bit 5 is 0.
- R5: When the override of output j is enabled and its value is permitted, the output takes the override value, regardless of `act_req`.
- R6: An override value of 0 requires `allow0[j]` and a value of 1 requires `allow1[j]`. An override that is not permitted is ignored, and the output keeps its base value.
- R7: Writing `lock_wdata=0` with `lock_we` clears `cfg_unlocked`. From that point on, writes to the permission bits are ignored. Writing 1 does not set the lock bit again; only reset does.
- R8: The override enable and value registers stay writable after the lock.
- R9: Reset state:
  - `cfg_unlocked` is 1.
  - `allow0` is 1 on bits 4 and 5 and 0 elsewhere.
  - `allow1` is 0 everywhere.
  - Override enable is 1 on bits 4 and 5 and 0 elsewhere.
  - Override values are 0.
  - Inversion masks are 0.
  - As a result, bits 4 and 5 of `pin_out` are 0 and the keys pass through.
- R10: Configuration written with a write-enable strobe takes effect at that clock edge. `pin_out` and `det_in` respond to `raw_in` and `act_*` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | 4 | Raw passthrough inputs |
| act_req | input | 6 | Per-output action request from detection logic |
| act_val | input | 6 | Per-output action value |
| allow_we | input | 1 | Write strobe for the permission bits |
| allow0_wdata | input | 6 | Permit-force-0 bits |
| allow1_wdata | input | 6 | Permit-force-1 bits |
| lock_we | input | 1 | Write strobe for the lock bit |
| lock_wdata | input | 1 | Lock bit data; 0 locks |
| ovr_we | input | 1 | Write strobe for override controls |
| ovr_en_wdata | input | 6 | Override enables |
| ovr_val_wdata | input | 6 | Override values |
| inv_we | input | 1 | Write strobe for inversion masks |
| inv_in_wdata | input | 4 | Input inversion mask |
| inv_out_wdata | input | 4 | Output inversion mask |
| det_in | output | 4 | Inverted inputs for detection logic |
| pin_out | output | 6 | Final output levels |
| cfg_unlocked | output | 1 | 1 while permission bits are writable |

## Verification
The bench sweeps every combination of input level, the two inversions, action request and value, the two permissions, and override enable and value, replicated on all six pins. It compares each pin against an arithmetic model. This sweep catches three kinds of error:
- a design that inverts before the override, which would flip forced values;
- a design that lets an override through without the permission for that value;
- a design that inverts the reset or write-protect pins.

Separate sequences lock the block and then try to widen the permissions, which would expose a design whose lock does not freeze them. They also try to re-set the lock, and they change the override afterwards, which would catch a design that freezes too much. The reset defaults are checked at the outputs after two separate resets.

// File: rtl/pin_ovr_pkg.sv
package pin_ovr_pkg;
  localparam int unsigned DEF_KEYS = 4;

  typedef struct packed {
    logic allow0;
    logic allow1;
    logic en;
    logic val;
  } pin_ovr_t;
endpackage

// File: rtl/pin_ovr_cfg.sv
module pin_ovr_cfg
  import pin_ovr_pkg::*;
#(
  parameter int unsigned NKEY = DEF_KEYS,
  localparam int unsigned NPIN = NKEY + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 allow_we,
  input  logic [NPIN-1:0]      allow0_wdata,
  input  logic [NPIN-1:0]      allow1_wdata,
  input  logic                 lock_we,
  input  logic                 lock_wdata,
  input  logic                 ovr_we,
  input  logic [NPIN-1:0]      ovr_en_wdata,
  input  logic [NPIN-1:0]      ovr_val_wdata,
  input  logic                 inv_we,
  input  logic [NKEY-1:0]      inv_in_wdata,
  input  logic [NKEY-1:0]      inv_out_wdata,
  output pin_ovr_t [NPIN-1:0]  cfg_o,
  output logic [NKEY-1:0]      inv_in_o,
  output logic [NKEY-1:0]      inv_out_o,
  output logic                 unlocked_o
);
  localparam logic [NPIN-1:0] SAFE_MASK = {2'b11, {NKEY{1'b0}}};

  logic [NPIN-1:0] allow0_q, allow1_q, en_q, val_q;
  logic            unlocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b1;
      allow0_q   <= SAFE_MASK;
      allow1_q   <= '0;
    end else begin
      if (lock_we && !lock_wdata) unlocked_q <= 1'b0;
      if (allow_we && unlocked_q) begin
        allow0_q <= allow0_wdata;
        allow1_q <= allow1_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= SAFE_MASK;
      val_q     <= '0;
      inv_in_o  <= '0;
      inv_out_o <= '0;
    end else begin
      if (ovr_we) begin
        en_q  <= ovr_en_wdata;
        val_q <= ovr_val_wdata;
      end
      if (inv_we) begin
        inv_in_o  <= inv_in_wdata;
        inv_out_o <= inv_out_wdata;
      end
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pack
    assign cfg_o[p] = '{allow0: allow0_q[p], allow1: allow1_q[p],
                        en: en_q[p], val: val_q[p]};
  end

  assign unlocked_o = unlocked_q;

  // R7: once cleared, the lock bit never sets again before reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> !unlocked_q);

  // R7: permission bits frozen while locked
  a_r7_allow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> ($stable(allow0_q) && $stable(allow1_q)));

  // R8: override controls still follow writes after lock
  a_r8_ovr_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked_q && ovr_we) |=> (val_q == $past(ovr_val_wdata)));
endmodule

// File: rtl/pin_ovr_mux.sv
module pin_ovr_mux
  import pin_ovr_pkg::*;
#(
  parameter int unsigned NKEY = DEF_KEYS,
  localparam int unsigned NPIN = NKEY + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIN-1:0]     base_i,
  input  pin_ovr_t [NPIN-1:0] cfg_i,
  input  logic [NKEY-1:0]     inv_out_i,
  output logic [NPIN-1:0]     pin_o
);
  logic [NPIN-1:0] chosen;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic permitted;
    assign permitted = cfg_i[p].en &&
                       (cfg_i[p].val ? cfg_i[p].allow1 : cfg_i[p].allow0);
    assign chosen[p] = permitted ? cfg_i[p].val : base_i[p];

    if (p < NKEY) begin : g_inv
      assign pin_o[p] = chosen[p] ^ inv_out_i[p];
    end else begin : g_plain
      assign pin_o[p] = chosen[p];
    end

    // R6: a value with no permission leaves the base value in place
    a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i[p].en && cfg_i[p].val && !cfg_i[p].allow1) |-> (chosen[p] == base_i[p]));

    // R5: a permitted override wins over base and action
    a_r5_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i[p].en && !cfg_i[p].val && cfg_i[p].allow0) |-> (pin_o[p] == (p < NKEY ? inv_out_i[p % NKEY] : 1'b0)));
  end
endmodule

// File: rtl/pin_ovr_top.sv
module pin_ovr_top
  import pin_ovr_pkg::*;
#(
  parameter int unsigned NKEY = DEF_KEYS,
  localparam int unsigned NPIN = NKEY + 2,
  localparam int unsigned EC_IDX = NKEY,
  localparam int unsigned WP_IDX = NKEY + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NKEY-1:0] raw_in,
  input  logic [NPIN-1:0] act_req,
  input  logic [NPIN-1:0] act_val,
  input  logic            allow_we,
  input  logic [NPIN-1:0] allow0_wdata,
  input  logic [NPIN-1:0] allow1_wdata,
  input  logic            lock_we,
  input  logic            lock_wdata,
  input  logic            ovr_we,
  input  logic [NPIN-1:0] ovr_en_wdata,
  input  logic [NPIN-1:0] ovr_val_wdata,
  input  logic            inv_we,
  input  logic [NKEY-1:0] inv_in_wdata,
  input  logic [NKEY-1:0] inv_out_wdata,
  output logic [NKEY-1:0] det_in,
  output logic [NPIN-1:0] pin_out,
  output logic            cfg_unlocked
);
  pin_ovr_t [NPIN-1:0] cfg;
  logic [NKEY-1:0]     inv_in, inv_out;
  logic [NPIN-1:0]     idle, base;

  pin_ovr_cfg #(.NKEY(NKEY)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .allow_we(allow_we), .allow0_wdata(allow0_wdata), .allow1_wdata(allow1_wdata),
    .lock_we(lock_we), .lock_wdata(lock_wdata),
    .ovr_we(ovr_we), .ovr_en_wdata(ovr_en_wdata), .ovr_val_wdata(ovr_val_wdata),
    .inv_we(inv_we), .inv_in_wdata(inv_in_wdata), .inv_out_wdata(inv_out_wdata),
    .cfg_o(cfg), .inv_in_o(inv_in), .inv_out_o(inv_out), .unlocked_o(cfg_unlocked)
  );

  assign det_in = raw_in ^ inv_in;

  always_comb begin
    idle               = '0;
    idle[NKEY-1:0]     = det_in;
    idle[EC_IDX]       = 1'b1;
    idle[WP_IDX]       = 1'b0;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_base
    assign base[p] = act_req[p] ? act_val[p] : idle[p];
  end

  pin_ovr_mux #(.NKEY(NKEY)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .base_i(base), .cfg_i(cfg), .inv_out_i(inv_out), .pin_o(pin_out)
  );

  // R4: with no override enabled, the write-protect output is low unless an action drives it
  a_r4_wp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[WP_IDX].en && !act_req[WP_IDX]) |-> !pin_out[WP_IDX]);
endmodule

// File: tb/pin_ovr_top_bench.sv
module pin_ovr_top_bench;
  localparam int NK = 4;
  localparam int NP = NK + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NK-1:0] raw_in = '0, inv_in_wdata = '0, inv_out_wdata = '0, det_in;
  logic [NP-1:0] act_req = '0, act_val = '0, allow0_wdata = '0, allow1_wdata = '0;
  logic [NP-1:0] ovr_en_wdata = '0, ovr_val_wdata = '0, pin_out;
  logic allow_we = 0, lock_we = 0, lock_wdata = 1, ovr_we = 0, inv_we = 0, cfg_unlocked;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_ovr_top u_pin_ovr_top (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .act_req(act_req), .act_val(act_val),
    .allow_we(allow_we), .allow0_wdata(allow0_wdata), .allow1_wdata(allow1_wdata),
    .lock_we(lock_we), .lock_wdata(lock_wdata), .ovr_we(ovr_we),
    .ovr_en_wdata(ovr_en_wdata), .ovr_val_wdata(ovr_val_wdata), .inv_we(inv_we),
    .inv_in_wdata(inv_in_wdata), .inv_out_wdata(inv_out_wdata),
    .det_in(det_in), .pin_out(pin_out), .cfg_unlocked(cfg_unlocked));

  function automatic logic model(int idx, logic r, logic ii, logic io, logic ar, logic av,
                                 logic a0, logic a1, logic en, logic v);
    logic b, o;
    b = (idx < NK) ? (r ^ ii) : (idx == NK);
    if (ar) b = av;
    o = (en && (v ? a1 : a0)) ? v : b;
    if (idx < NK) o = o ^ io;
    return o;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset defaults
    raw_in = 4'b1010;
    #1;
    chk("R9 unlocked", cfg_unlocked, 1);
    chk("R9 pin_out", pin_out, {2'b00, 4'b1010});
    chk("R9 R1 det_in", det_in, 4'b1010);
    // R10 outputs respond to inputs without a clock
    raw_in = 4'b0110; #1;
    chk("R10 R1 comb passthrough", pin_out[3:0], 4'b0110);

    // sweep R1..R6 and R10 with all pins given the same pattern
    for (int k = 0; k < 512; k++) begin
      logic r, ii, io, ar, av, a0, a1, en, v;
      {r, ii, io, ar, av, a0, a1, en, v} = 9'(k);
      @(negedge clk);
      allow_we = 1; allow0_wdata = {NP{a0}}; allow1_wdata = {NP{a1}};
      ovr_we = 1; ovr_en_wdata = {NP{en}}; ovr_val_wdata = {NP{v}};
      inv_we = 1; inv_in_wdata = {NK{ii}}; inv_out_wdata = {NK{io}};
      raw_in = {NK{r}}; act_req = {NP{ar}}; act_val = {NP{av}};
      @(negedge clk);
      allow_we = 0; ovr_we = 0; inv_we = 0;
      chk("R2 det_in", det_in, {NK{r ^ ii}});
      for (int p = 0; p < NP; p++)
        chk("R1 R3 R4 R5 R6 sweep", pin_out[p], model(p, r, ii, io, ar, av, a0, a1, en, v));
    end

    // R7 lock then attempt to widen permissions
    @(negedge clk);
    act_req = '0; raw_in = 4'b0000;
    allow_we = 1; allow0_wdata = '1; allow1_wdata = '0;
    ovr_we = 1; ovr_en_wdata = '0; ovr_val_wdata = '0;
    inv_we = 1; inv_in_wdata = '0; inv_out_wdata = '0;
    @(negedge clk);
    allow_we = 0; ovr_we = 0; inv_we = 0;
    lock_we = 1; lock_wdata = 0;
    @(negedge clk);
    lock_we = 0;
    chk("R7 lock clears", cfg_unlocked, 0);
    allow_we = 1; allow1_wdata = '1; allow0_wdata = '0;
    @(negedge clk);
    allow_we = 0;
    ovr_we = 1; ovr_en_wdata = '1; ovr_val_wdata = '1;
    @(negedge clk);
    ovr_we = 0;
    chk("R7 allow1 write ignored", pin_out, {2'b01, 4'b0000});
    lock_we = 1; lock_wdata = 1;
    @(negedge clk);
    lock_we = 0;
    chk("R7 lock not re-set", cfg_unlocked, 0);
    // R8 override still writable; allow0 kept from before lock
    ovr_we = 1; ovr_en_wdata = '1; ovr_val_wdata = '0; raw_in = 4'b1111;
    @(negedge clk);
    ovr_we = 0;
    chk("R8 override after lock", pin_out, 6'b000000);
    ovr_we = 1; ovr_en_wdata = '0;
    @(negedge clk);
    ovr_we = 0;
    chk("R8 R4 release", pin_out, {2'b01, 4'b1111});

    // R9 reset restores defaults and unlock
    do_reset();
    raw_in = 4'b0011; #1;
    chk("R9 R7 unlocked after reset", cfg_unlocked, 1);
    chk("R9 pin_out after reset", pin_out, {2'b00, 4'b0011});
    // R4 action request on reset pin loses to default override (R5)
    act_req = 6'b010000; act_val = 6'b010000; #1;
    chk("R5 override beats action", pin_out[4], 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule